// File: doc/BRIEF.md
# Byte-Memory Boot Loader

This block fills internal program memory from an external byte-wide memory straight after reset. While reset is asserted it loads its own registers with fixed defaults: external page 0, external byte address 0, internal word address 0, and a count of 32 words. Transfer direction and word type are fixed at "byte memory into 24-bit program words". It also samples the boot-mode inputs during reset. If those inputs select byte-memory boot, it raises a hold signal that keeps the processor stalled.

After reset is released, the loader reads three bytes for every program word. It places the first byte in the most significant position and writes each finished word into program memory. The read handshake is a level request answered by an acknowledge, and the memory may insert any number of wait cycles. When the last of the 32 words has been written, the hold drops, a one-cycle done pulse marks the release, and execution begins at address 0. When any other boot source is selected, the loader does nothing and never holds the processor.

Top module: `byte_boot_loader`

## Requirements
- R1: The boot-mode inputs are sampled in every clock cycle in which `rst_n` is low. Code 3'b000 selects byte-memory boot, and loading begins only after `rst_n` returns high.
- R2: While `rst_n` is low, `mem_rd`, `pm_we` and `done` are 0, and `hold` equals 1 exactly when the sampled mode is 3'b000.
- R3: The first byte read uses `mem_page` 0 and `mem_addr` 0. The byte address rises by one for each acknowledged byte and stays unchanged while a request waits for `mem_ack`.
- R4: Each 24-bit program word is built from three consecutively acknowledged bytes, first byte in bits 23:16, second byte in bits 15:8, third byte in bits 7:0.
- R5: Exactly 32 program-memory writes occur, to word addresses 0, 1, 2 … 31 in that order, each lasting one cycle with `pm_we` high.
- R6: `hold` stays 1 through every program-memory write. It falls in the cycle right after the 32nd write, and `done` is high for that one cycle only.
- R7: With any mode code other than 3'b000, `hold` is 0 and `mem_rd`, `pm_we` and `done` stay 0.
- R8: After the done pulse, no further byte reads or program-memory writes take place until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| boot_mode | input | 3 | Boot source select, sampled during reset |
| mem_rd | output | 1 | Byte read request, held until acknowledged |
| mem_page | output | 8 | External memory page |
| mem_addr | output | 14 | External byte address |
| mem_data | input | 8 | Byte returned by external memory |
| mem_ack | input | 1 | Byte valid; completes the current request |
| pm_we | output | 1 | Program-memory write strobe |
| pm_addr | output | 14 | Program-memory word address |
| pm_wdata | output | 24 | Assembled program word |
| hold | output | 1 | Processor stall; high while booting |
| done | output | 1 | One-cycle pulse when the boot completes |

## Verification
A stuck or skipped byte counter shows at the next write as a word with its bytes rotated or taken from the wrong address. A wrong word count shows as a missing or extra write and as a done pulse that comes early or late, so it appears no later than the end of the 32-word transfer. A wrong mode decode shows in the first cycle after reset, either as a hold level that disagrees with the selected mode or as a read request that should not be there. Every mode code is swept, each combined with acknowledge latencies of zero to three wait cycles, and every word is compared against a value computed from its byte addresses.

// File: rtl/byte_boot_loader.sv
module byte_boot_loader #(
  parameter int EXT_AW     = 14,
  parameter int INT_AW     = 14,
  parameter int PAGE_W     = 8,
  parameter int BOOT_WORDS = 32,
  parameter int MODE_W     = 3,
  parameter logic [MODE_W-1:0] BOOT_CODE = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] boot_mode,
  output logic              mem_rd,
  output logic [PAGE_W-1:0] mem_page,
  output logic [EXT_AW-1:0] mem_addr,
  input  logic [7:0]        mem_data,
  input  logic              mem_ack,
  output logic              pm_we,
  output logic [INT_AW-1:0] pm_addr,
  output logic [23:0]       pm_wdata,
  output logic              hold,
  output logic              done
);

  localparam int CNT_W = $clog2(BOOT_WORDS + 1);
  localparam int BYTES_PER_WORD = 3;

  typedef enum logic [1:0] {S_START, S_FETCH, S_WRITE, S_IDLE} state_t;

  state_t            state;
  logic              boot_sel;
  logic [PAGE_W-1:0] page;
  logic [EXT_AW-1:0] eaddr;
  logic [INT_AW-1:0] iaddr;
  logic [CNT_W-1:0]  wcount;
  logic [1:0]        bcnt;
  logic [23:0]       asm_word;

  always_ff @(posedge clk) begin
    done <= 1'b0;
    if (!rst_n) begin
      boot_sel <= (boot_mode == BOOT_CODE);
      hold     <= (boot_mode == BOOT_CODE);
      state    <= S_START;
      page     <= '0;
      eaddr    <= '0;
      iaddr    <= '0;
      wcount   <= CNT_W'(BOOT_WORDS);
      bcnt     <= '0;
      asm_word <= '0;
    end else begin
      case (state)
        S_START: state <= boot_sel ? S_FETCH : S_IDLE;
        S_FETCH: if (mem_ack) begin
          asm_word <= {asm_word[15:0], mem_data};
          eaddr    <= eaddr + 1'b1;
          if (bcnt == 2'(BYTES_PER_WORD - 1)) begin
            bcnt  <= '0;
            state <= S_WRITE;
          end else begin
            bcnt <= bcnt + 1'b1;
          end
        end
        S_WRITE: begin
          iaddr  <= iaddr + 1'b1;
          wcount <= wcount - 1'b1;
          if (wcount == CNT_W'(1)) begin
            state <= S_IDLE;
            hold  <= 1'b0;
            done  <= 1'b1;
          end else begin
            state <= S_FETCH;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign mem_rd   = (state == S_FETCH);
  assign mem_page = page;
  assign mem_addr = eaddr;
  assign pm_we    = (state == S_WRITE);
  assign pm_addr  = iaddr;
  assign pm_wdata = asm_word;

  // R6
  write_in_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pm_we |-> hold);

  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6
  hold_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold) |-> done);

  // R3
  addr_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && !mem_ack) |=> $stable(mem_addr));

  // R7
  other_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !boot_sel |-> (!mem_rd && !pm_we && !hold));

  // R5
  count_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pm_we |-> (wcount != '0));

endmodule

// File: tb/test_byte_boot_loader.sv
`timescale 1ns/1ps
module test_byte_boot_loader;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  boot_mode = 3'd0;
  logic        mem_rd, pm_we, hold, done;
  logic [7:0]  mem_page;
  logic [13:0] mem_addr, pm_addr;
  logic [7:0]  mem_data = 8'h00;
  logic        mem_ack = 1'b0;
  logic [23:0] pm_wdata;

  always #2.5 clk = ~clk;

  byte_boot_loader i_byte_boot_loader (
    .clk(clk), .rst_n(rst_n), .boot_mode(boot_mode),
    .mem_rd(mem_rd), .mem_page(mem_page), .mem_addr(mem_addr),
    .mem_data(mem_data), .mem_ack(mem_ack),
    .pm_we(pm_we), .pm_addr(pm_addr), .pm_wdata(pm_wdata),
    .hold(hold), .done(done)
  );

  int total = 0, fails = 0;
  int lat = 0, wait_cnt = 0;
  int bytes_seen = 0, words = 0, done_cnt = 0;
  int rd_cnt = 0, we_cnt = 0, post_err = 0, hold_err = 0, addr_err = 0;

  function automatic logic [7:0] mval(input int a);
    return 8'((a * 29 + 7) & 255);
  endfunction

  function automatic logic [23:0] wexp(input int k);
    return {mval(3*k), mval(3*k+1), mval(3*k+2)};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial forever begin
    @(negedge clk);
    if (rst_n) begin
      if (done_cnt > 0 && (mem_rd || pm_we)) post_err++;
      if (mem_rd) begin
        rd_cnt++;
        if (mem_addr != 14'(bytes_seen) || mem_page != 8'd0) addr_err++;
      end
      if (pm_we) begin
        we_cnt++;
        chk(pm_addr == 14'(words), "R5 pm_addr", int'(pm_addr), words);
        chk(pm_wdata == wexp(words), "R4 pm_wdata", int'(pm_wdata), int'(wexp(words)));
        if (!hold) hold_err++;
        words++;
      end
      if (done) begin
        done_cnt++;
        chk(words == 32 && !hold, "R6 done timing", words, 32);
      end
      if (!hold && boot_mode == 3'd0 && words < 32) hold_err++;
    end
    if (mem_rd && rst_n) begin
      if (wait_cnt == lat) begin
        mem_ack = 1'b1; mem_data = mval(int'(mem_addr)); wait_cnt = 0; bytes_seen++;
      end else begin
        mem_ack = 1'b0; mem_data = 8'hA5; wait_cnt++;
      end
    end else begin
      mem_ack = 1'b0; wait_cnt = 0;
    end
  end

  task automatic run(input logic [2:0] m, input int l);
    bit is_boot;
    is_boot = (m == 3'd0);
    @(negedge clk);
    rst_n = 1'b0; boot_mode = m; lat = l;
    bytes_seen = 0; words = 0; done_cnt = 0;
    rd_cnt = 0; we_cnt = 0; post_err = 0; hold_err = 0; addr_err = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 R2: reset state reflects the sampled mode
    chk(hold == is_boot, "R2 hold in reset", hold, is_boot);
    chk(!mem_rd && !pm_we && !done, "R2 idle outputs in reset",
        {mem_rd, pm_we, done}, 0);
    rst_n = 1'b1;
    if (is_boot) begin
      for (int i = 0; i < 2000 && done_cnt == 0; i++) @(negedge clk);
      repeat (20) @(negedge clk);
      chk(words == 32, "R5 word count", words, 32);
      chk(addr_err == 0 && bytes_seen == 96, "R3 byte addressing", bytes_seen, 96);
      chk(done_cnt == 1, "R6 done pulses", done_cnt, 1);
      chk(hold_err == 0 && !hold, "R6 hold span", hold_err, 0);
      chk(post_err == 0, "R8 quiet after done", post_err, 0);
      chk(rd_cnt >= 96, "R1 boot started", rd_cnt, 96);
    end else begin
      repeat (200) @(negedge clk);
      chk(rd_cnt == 0 && we_cnt == 0, "R7 no traffic", rd_cnt + we_cnt, 0);
      chk(done_cnt == 0 && !hold, "R7 no hold or done", done_cnt + int'(hold), 0);
    end
  endtask

  initial begin
    for (int l = 0; l < 4; l++)
      for (int m = 0; m < 8; m++)
        run(3'(m), l);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog R1 actual=hung expected=finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule